// File: doc/BRIEF.md
# DMA Coherence Entry Bridge

This block is where DMA traffic enters the coherent domain. A requester, such as an on-chip network interface or an external bus master, hands it one request at a time: a read or a write, a byte address, one cache line of write data, and a per-byte strobe mask. The bridge compares the line address against a main-memory window held in two configuration inputs. It then issues the matching system bus transaction and returns a single response to the requester, with read data or an error flag.

Requests inside the window become cacheable coherent transactions that always move a whole line. A write that does not set every strobe cannot be sent to memory as a coherent line write on its own. The bridge therefore reads the line with exclusive ownership, merges the new bytes into it, and writes the full line back. Requests outside the window are sent as uncacheable transactions. These carry the requester's strobes as the bus byte enables, so a partial access costs one transaction.

The cache line is 32 bytes by default. The bus carries a whole line in each direction. Only one request is in flight at any time.

Top module: `dma_coh_bridge`

## Requirements
- R1: A request targets memory when its line address (byte address with the low log2(LINE_BYTES) bits cleared) is at least `cfg_mem_base` and at most `cfg_mem_limit`, both bounds inclusive; every bus address is that line address.
- R2: A memory read issues one transaction of type 1 (coherent read) with all byte enables set, and its response returns the bus read data unchanged.
- R3: A memory write with every strobe set issues exactly one transaction of type 3 (coherent line write) with all byte enables set and the request data, with no read before it.
- R4: A memory write with any strobe clear issues type 2 (coherent read-exclusive) with all byte enables set, then type 3 with all byte enables set.
- R5: The line written in the second step of R4 holds request byte k wherever strobe bit k is set, and byte k of the exclusive read data everywhere else.
- R6: A read outside memory issues one transaction of type 4 (uncacheable read) whose byte enables equal the request strobes.
- R7: A write outside memory issues one transaction of type 5 (uncacheable write) whose byte enables equal the strobes and whose data equals the request data.
- R8: `req_ready` is low from the cycle after a request is accepted until the cycle its response is delivered, so a request raised during a sequence waits and is carried out afterwards.
- R9: An error on the read-exclusive step ends the sequence: the write step is not issued, and the response has `rsp_err` set.
- R10: An error on any other bus transaction, including the write step of R4, is returned with `rsp_err` set.
- R11: While `bus_valid` is high and `bus_ready` is low, the type, address, byte enables and data on the bus stay unchanged.
- R12: After reset `req_ready` is high and both `bus_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mem_base | input | ADDR_W | Lowest line address of main memory |
| cfg_mem_limit | input | ADDR_W | Highest line address of main memory |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | LINE_BYTES*8 | Write data for the whole line |
| req_strb | input | LINE_BYTES | Per-byte strobes |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response carries an error |
| rsp_rdata | output | LINE_BYTES*8 | Read data of the response |
| bus_valid | output | 1 | Bus transaction offered |
| bus_ready | input | 1 | Bus accepts the transaction |
| bus_type | output | 3 | Transaction type code |
| bus_addr | output | ADDR_W | Line address |
| bus_wdata | output | LINE_BYTES*8 | Line write data |
| bus_be | output | LINE_BYTES | Byte enables |
| bus_rsp_valid | input | 1 | Bus response pulse |
| bus_rsp_err | input | 1 | Bus response error |
| bus_rsp_rdata | input | LINE_BYTES*8 | Bus response data |

## Verification
The hardest cases to reach are the two error exits of the read-merge-write sequence and a request that arrives while that sequence is still running. Each expected bus transaction in the scoreboard carries the error flag and the line data the bus model must return. This lets the stimulus fail the exclusive read, or the later write, of one chosen request. In the busy case, a second request is raised the cycle after a partial memory write is accepted and stays held through both bus steps. Boundary addresses exactly at the base, on the last line of the window and one line past it exercise the inclusive comparison.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  typedef enum logic [2:0] {
    BT_NONE     = 3'd0,
    BT_COH_RD   = 3'd1,
    BT_COH_RDEX = 3'd2,
    BT_COH_WR   = 3'd3,
    BT_UNC_RD   = 3'd4,
    BT_UNC_WR   = 3'd5
  } bus_type_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/dcb_region_check.sv
module dcb_region_check #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] line_addr,
  input  logic [ADDR_W-1:0] lo_bound,
  input  logic [ADDR_W-1:0] hi_bound,
  output logic              in_region
);
  // Both bounds inclusive; bounds are line addresses.
  assign in_region = (line_addr >= lo_bound) && (line_addr <= hi_bound);
endmodule

// File: rtl/dcb_byte_merge.sv
module dcb_byte_merge #(
  parameter int LINE_BYTES = 32
) (
  input  logic [LINE_BYTES*8-1:0] old_line,
  input  logic [LINE_BYTES*8-1:0] new_line,
  input  logic [LINE_BYTES-1:0]   sel,
  output logic [LINE_BYTES*8-1:0] merged
);
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign merged[b*8 +: 8] = sel[b] ? new_line[b*8 +: 8] : old_line[b*8 +: 8];
  end
endmodule

// File: rtl/dma_coh_bridge.sv
module dma_coh_bridge
  import dcb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       cfg_mem_base,
  input  logic [ADDR_W-1:0]       cfg_mem_limit,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LINE_BYTES*8-1:0] req_wdata,
  input  logic [LINE_BYTES-1:0]   req_strb,
  output logic                    rsp_valid,
  output logic                    rsp_err,
  output logic [LINE_BYTES*8-1:0] rsp_rdata,
  output logic                    bus_valid,
  input  logic                    bus_ready,
  output logic [2:0]              bus_type,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [LINE_BYTES*8-1:0] bus_wdata,
  output logic [LINE_BYTES-1:0]   bus_be,
  input  logic                    bus_rsp_valid,
  input  logic                    bus_rsp_err,
  input  logic [LINE_BYTES*8-1:0] bus_rsp_rdata
);

  localparam int DATA_W = LINE_BYTES * 8;
  localparam logic [ADDR_W-1:0]     OFF_MASK = ADDR_W'(LINE_BYTES - 1);
  localparam logic [LINE_BYTES-1:0] ALL_BE   = '1;

  seq_state_e              st_q;
  logic                    rmw_q;        // read-exclusive step outstanding
  logic [LINE_BYTES-1:0]   strb_q;
  logic [DATA_W-1:0]       new_data_q;
  logic                    bus_valid_q;
  bus_type_e               bus_type_q;
  logic [ADDR_W-1:0]       bus_addr_q;
  logic [DATA_W-1:0]       bus_wdata_q;
  logic [LINE_BYTES-1:0]   bus_be_q;
  logic                    rsp_valid_q;
  logic                    rsp_err_q;
  logic [DATA_W-1:0]       rsp_rdata_q;

  logic [ADDR_W-1:0]       line_addr;
  logic                    to_memory;
  logic                    full_line;
  logic [DATA_W-1:0]       merged_line;
  logic                    accept;

  assign line_addr = req_addr & ~OFF_MASK;
  assign full_line = &req_strb;
  assign accept    = req_valid && (st_q == ST_IDLE);

  dcb_region_check #(.ADDR_W(ADDR_W)) region_i (
    .line_addr (line_addr),
    .lo_bound  (cfg_mem_base),
    .hi_bound  (cfg_mem_limit),
    .in_region (to_memory)
  );

  dcb_byte_merge #(.LINE_BYTES(LINE_BYTES)) merge_i (
    .old_line (bus_rsp_rdata),
    .new_line (new_data_q),
    .sel      (strb_q),
    .merged   (merged_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      rmw_q       <= 1'b0;
      strb_q      <= '0;
      new_data_q  <= '0;
      bus_valid_q <= 1'b0;
      bus_type_q  <= BT_NONE;
      bus_addr_q  <= '0;
      bus_wdata_q <= '0;
      bus_be_q    <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            strb_q      <= req_strb;
            new_data_q  <= req_wdata;
            bus_addr_q  <= line_addr;
            bus_wdata_q <= req_wdata;
            bus_valid_q <= 1'b1;
            st_q        <= ST_ISSUE;
            if (to_memory) begin
              bus_be_q <= ALL_BE;
              if (!req_write) begin
                bus_type_q <= BT_COH_RD;
              end else if (full_line) begin
                bus_type_q <= BT_COH_WR;
              end else begin
                bus_type_q <= BT_COH_RDEX;
                rmw_q      <= 1'b1;
              end
            end else begin
              bus_be_q   <= req_strb;
              bus_type_q <= req_write ? BT_UNC_WR : BT_UNC_RD;
            end
          end
        end
        ST_ISSUE: begin
          if (bus_ready) begin
            bus_valid_q <= 1'b0;
            st_q        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (bus_rsp_valid) begin
            rmw_q <= 1'b0;
            if (rmw_q && !bus_rsp_err) begin
              bus_wdata_q <= merged_line;
              bus_type_q  <= BT_COH_WR;
              bus_valid_q <= 1'b1;
              st_q        <= ST_ISSUE;
            end else begin
              rsp_valid_q <= 1'b1;
              rsp_err_q   <= bus_rsp_err;
              rsp_rdata_q <= bus_rsp_rdata;
              st_q        <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;
  assign bus_valid = bus_valid_q;
  assign bus_type  = bus_type_q;
  assign bus_addr  = bus_addr_q;
  assign bus_wdata = bus_wdata_q;
  assign bus_be    = bus_be_q;

endmodule

// File: rtl/dcb_checker.sv
module dcb_checker
  import dcb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:0]       cfg_mem_base,
  input logic [ADDR_W-1:0]       cfg_mem_limit,
  input logic                    req_ready,
  input logic                    rsp_valid,
  input logic                    bus_valid,
  input logic                    bus_ready,
  input logic [2:0]              bus_type,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [LINE_BYTES*8-1:0] bus_wdata,
  input logic [LINE_BYTES-1:0]   bus_be
);

  logic is_coh, is_unc, in_win;
  assign is_coh = (bus_type == BT_COH_RD) || (bus_type == BT_COH_RDEX) || (bus_type == BT_COH_WR);
  assign is_unc = (bus_type == BT_UNC_RD) || (bus_type == BT_UNC_WR);
  assign in_win = (bus_addr >= cfg_mem_base) && (bus_addr <= cfg_mem_limit);

  p_busy_blocks_req_r8: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> !req_ready);

  p_single_rsp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_hold_until_taken_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_type) && $stable(bus_addr)
                                   && $stable(bus_be) && $stable(bus_wdata)));

  p_coh_full_line_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && is_coh) |-> (&bus_be));

  p_coh_inside_window_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && is_coh) |-> in_win);

  p_unc_outside_window_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && is_unc) |-> !in_win);

  p_known_type_r2: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (is_coh || is_unc));

endmodule

bind dma_coh_bridge dcb_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .cfg_mem_base  (cfg_mem_base),
  .cfg_mem_limit (cfg_mem_limit),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .bus_valid     (bus_valid),
  .bus_ready     (bus_ready),
  .bus_type      (bus_type),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_be        (bus_be)
);

// File: tb/dma_coh_bridge_tb_top.sv
`timescale 1ns/1ps
module dma_coh_bridge_tb_top;

  localparam logic [31:0] BASE  = 32'h0001_0000;
  localparam logic [31:0] LIMIT = 32'h0001_FFE0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_addr = '0, req_strb = '0;
  logic [255:0] req_wdata = '0;
  logic         req_ready, rsp_valid, rsp_err;
  logic [255:0] rsp_rdata;
  logic         bus_valid;
  logic         bus_ready = 1'b0;
  logic [2:0]   bus_type;
  logic [31:0]  bus_addr, bus_be;
  logic [255:0] bus_wdata;
  logic         bus_rsp_valid = 1'b0, bus_rsp_err = 1'b0;
  logic [255:0] bus_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  dma_coh_bridge dut_i (
    .clk(clk), .rst(rst), .cfg_mem_base(BASE), .cfg_mem_limit(LIMIT),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_type(bus_type),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err), .bus_rsp_rdata(bus_rsp_rdata)
  );

  typedef struct {
    logic [2:0]   t;
    logic [31:0]  a;
    logic [31:0]  be;
    logic [255:0] wd;
    logic         chk_wd;
    logic         err;
    logic [255:0] rd;
    string        rq;
  } bus_item_t;

  typedef struct {
    logic         err;
    logic         chk_rd;
    logic [255:0] rd;
    string        rq;
  } rsp_item_t;

  bus_item_t exp_bus[$];
  rsp_item_t exp_rsp[$];
  int checks = 0;
  int fails  = 0;
  int txn_no = 0;

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mdl_line(input logic [31:0] a);
    logic [255:0] r;
    for (int k = 0; k < 32; k++) r[k*8 +: 8] = (a[12:5] * 8'd13 + 8'(k)) ^ 8'h5A;
    return r;
  endfunction

  // Driver: pushes expectations, then performs the request handshake.
  task automatic send(input logic wr, input logic [31:0] addr, input logic [255:0] wd,
                      input logic [31:0] strb, input int err_phase, input string rq);
    logic [31:0]  al;
    logic         mem;
    logic [255:0] old, mg;
    bus_item_t    bi;
    rsp_item_t    ri;
    al  = addr & ~32'd31;
    mem = (al >= BASE) && (al <= LIMIT);
    old = mdl_line(al);
    bi.a = al; bi.wd = wd; bi.rd = old; bi.rq = rq; bi.err = (err_phase == 1);
    ri.rd = old; ri.rq = rq; ri.err = (err_phase != 0); ri.chk_rd = 1'b0;
    if (mem) begin
      bi.be = '1;
      if (!wr) begin
        bi.t = 3'd1; bi.chk_wd = 1'b0; ri.chk_rd = (err_phase == 0);
        exp_bus.push_back(bi);
      end else if (&strb) begin
        bi.t = 3'd3; bi.chk_wd = 1'b1;
        exp_bus.push_back(bi);
      end else begin
        bi.t = 3'd2; bi.chk_wd = 1'b0;
        exp_bus.push_back(bi);
        if (err_phase != 1) begin
          for (int k = 0; k < 32; k++) mg[k*8 +: 8] = strb[k] ? wd[k*8 +: 8] : old[k*8 +: 8];
          bi.t = 3'd3; bi.wd = mg; bi.chk_wd = 1'b1; bi.err = (err_phase == 2);
          exp_bus.push_back(bi);
        end
      end
    end else begin
      bi.t = wr ? 3'd5 : 3'd4; bi.be = strb; bi.chk_wd = wr;
      ri.chk_rd = !wr && (err_phase == 0);
      exp_bus.push_back(bi);
    end
    exp_rsp.push_back(ri);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_strb = strb;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_bus.size() != 0 || exp_rsp.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Bus model / monitor: compares each offered transaction, then answers it.
  initial begin
    bus_item_t it;
    forever begin
      @(negedge clk);
      if (!rst && bus_valid) begin
        if (exp_bus.size() == 0) begin
          chk(1'b0, "R9", "unexpected bus transaction type", 256'(bus_type), 256'(0));
          it.err = 1'b0; it.rd = '0;
        end else begin
          it = exp_bus.pop_front();
          chk(bus_type == it.t, it.rq, "bus_type", 256'(bus_type), 256'(it.t));
          chk(bus_addr == it.a, it.rq, "bus_addr", 256'(bus_addr), 256'(it.a));
          chk(bus_be == it.be, it.rq, "bus_be", 256'(bus_be), 256'(it.be));
          if (it.chk_wd) chk(bus_wdata == it.wd, it.rq, "bus_wdata", bus_wdata, it.wd);
        end
        chk(req_ready == 1'b0, "R8", "req_ready during bus txn", 256'(req_ready), 256'(0));
        repeat (txn_no % 3) @(negedge clk);
        txn_no++;
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        @(negedge clk);
        bus_rsp_valid = 1'b1; bus_rsp_err = it.err; bus_rsp_rdata = it.rd;
        @(negedge clk);
        bus_rsp_valid = 1'b0; bus_rsp_err = 1'b0;
      end
    end
  end

  // Response monitor.
  initial begin
    rsp_item_t r;
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        if (exp_rsp.size() == 0) begin
          chk(1'b0, "R8", "unexpected response", 256'(1), 256'(0));
        end else begin
          r = exp_rsp.pop_front();
          chk(rsp_err == r.err, r.rq, "rsp_err", 256'(rsp_err), 256'(r.err));
          if (r.chk_rd) chk(rsp_rdata == r.rd, r.rq, "rsp_rdata", rsp_rdata, r.rd);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(req_ready == 1'b1, "R12", "req_ready", 256'(req_ready), 256'(1));
    chk(bus_valid == 1'b0, "R12", "bus_valid", 256'(bus_valid), 256'(0));
    chk(rsp_valid == 1'b0, "R12", "rsp_valid", 256'(rsp_valid), 256'(0));

    send(1'b0, 32'h0001_0043, '0, 32'hFFFF_FFFF, 0, "R2");                 wait_idle();
    send(1'b1, 32'h0001_2200, {8{32'hC0DE_0001}}, 32'hFFFF_FFFF, 0, "R3"); wait_idle();
    send(1'b1, 32'h0001_3300, {8{32'hBEEF_0002}}, 32'h0000_00F0, 0, "R4"); wait_idle();
    send(1'b1, 32'h0001_4400, {8{32'h1234_5678}}, 32'hAAAA_5555, 0, "R5"); wait_idle();
    send(1'b0, 32'h2000_0010, '0, 32'h0000_FF00, 0, "R6");                 wait_idle();
    send(1'b1, 32'h2000_0104, {8{32'hFACE_0003}}, 32'h0000_000F, 0, "R7"); wait_idle();
    send(1'b1, 32'h3000_0000, {8{32'h0F0F_0004}}, 32'hFFFF_FFFF, 0, "R7"); wait_idle();
    // R1 window boundaries
    send(1'b0, BASE,                '0, 32'hFFFF_FFFF, 0, "R1");           wait_idle();
    send(1'b0, LIMIT + 32'd31,      '0, 32'hFFFF_FFFF, 0, "R1");           wait_idle();
    send(1'b0, LIMIT + 32'd32,      '0, 32'h0000_0003, 0, "R1");           wait_idle();
    send(1'b1, BASE - 32'd1, {8{32'h5555_0005}}, 32'h8000_0000, 0, "R1");  wait_idle();
    // R9 error on the read-exclusive step, R10 on the write step and on a plain read
    send(1'b1, 32'h0001_5500, {8{32'hDEAD_0006}}, 32'h0000_0001, 1, "R9"); wait_idle();
    send(1'b1, 32'h0001_6600, {8{32'hDEAD_0007}}, 32'hFF00_0000, 2, "R10"); wait_idle();
    send(1'b0, 32'h0001_7700, '0, 32'hFFFF_FFFF, 1, "R10");                wait_idle();
    send(1'b0, 32'h2000_0200, '0, 32'h0000_00FF, 1, "R10");                wait_idle();
    // R8 request raised while a merge sequence is in progress
    send(1'b1, 32'h0001_8800, {8{32'hABCD_0008}}, 32'h00FF_FF00, 0, "R8");
    send(1'b0, 32'h0001_9900, '0, 32'hFFFF_FFFF, 0, "R8");
    wait_idle();
    send(1'b1, 32'h0001_AA00, {8{32'h7777_0009}}, 32'h0000_0000, 0, "R5"); wait_idle();

    chk(exp_bus.size() == 0, "R9", "leftover bus expectations", 256'(exp_bus.size()), 256'(0));
    chk(exp_rsp.size() == 0, "R10", "leftover responses", 256'(exp_rsp.size()), 256'(0));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule